// File: doc/BRIEF.md
# Timer event output generator

This block produces the level of one timer output pin from the events of a free-running counter. The counter supplies single-cycle strobes for two events: counter overflow and compare match. Control inputs choose which events act on the pin and how the pin answers them. In toggle style, each selected event flips the pin. In pulse style, each selected event gives a one-clock pulse away from a programmable idle level.

The pin returns to its idle level whenever no trigger source is selected or the counter is stopped. When the shared pin is configured as an input, the generator freezes its level register, so the pin resumes from the same value when it is switched back to an output. The pin level comes straight from a flop, and every response appears one clock after the inputs that cause it.

Top module: `tmr_evt_out`

## Requirements
- R1: A synchronous active-high reset sets the pin level to 0 on the next rising edge.
- R2: The trigger field `trig_sel` is decoded as follows: 0 selects no trigger, 1 selects overflow only, 2 selects both overflow and match, and 3 is treated the same as 0.
- R3: When `pin_is_input` is 0 and either `running` is 0 or no trigger is selected, the pin level equals `idle_level` after the next rising edge.
- R4: While `pin_is_input` is 1, the pin level keeps its value across the edge, whatever the other inputs are.
- R5: In toggle style (`toggle_mode` = 1), a selected event inverts the pin level at the next edge. A cycle with no selected event leaves the level unchanged.
- R6: In pulse style (`toggle_mode` = 0), a selected event drives the pin to the inverse of `idle_level` for exactly one cycle. Cycles with no selected event drive it to `idle_level`.
- R7: A match strobe acts only when `trig_sel` is 2. With `trig_sel` = 1 it has no effect on the pin.
- R8: When overflow and match strobe in the same cycle with `trig_sel` = 2, toggle style counts two inversions, so the level is unchanged. Pulse style gives a single one-cycle pulse.
- R9: The pin level is registered. It changes only at a rising edge, in response to the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 1 | Counter overflow strobe, one cycle |
| mat_evt | input | 1 | Compare match strobe, one cycle |
| running | input | 1 | Counter is running |
| pin_is_input | input | 1 | 1: pin is an input, level register frozen; 0: pin driven |
| trig_sel | input | 2 | Trigger source select (see R2) |
| toggle_mode | input | 1 | 1: toggle style; 0: pulse style |
| idle_level | input | 1 | Idle level of the pin |
| pin_level | output | 1 | Registered pin level |

## Verification
Overflow and match can fall in the same cycle when both sources are selected. This matters most in toggle style, where the two inversions must cancel, and in pulse style, where they must merge into one pulse. The bench forces both strobes high together in each style, both from a quiet level and right after a pulse. A behavioural model that counts events and takes their parity judges the result on every clock. A randomized phase also produces coincident strobes alongside stop, direction and mode changes.

// File: rtl/tgo_pkg.sv
package tgo_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_OVF  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_RSVD = 2'd3
  } trig_e;

  localparam int TRIG_W = 2;

  // Reserved encoding behaves as no trigger.
  function automatic logic trig_active(input logic [TRIG_W-1:0] sel);
    return (sel == TRIG_OVF) || (sel == TRIG_BOTH);
  endfunction

  function automatic logic match_enabled(input logic [TRIG_W-1:0] sel);
    return sel == TRIG_BOTH;
  endfunction
endpackage

// File: rtl/tgo_event_sel.sv
module tgo_event_sel
  import tgo_pkg::*;
(
  input  logic              ovf_evt,
  input  logic              mat_evt,
  input  logic [TRIG_W-1:0] trig_sel,
  output logic              any_hit,
  output logic              odd_hits
);
  logic ovf_sel;
  logic mat_sel;

  always_comb begin
    ovf_sel  = ovf_evt && trig_active(trig_sel);
    mat_sel  = mat_evt && match_enabled(trig_sel);
    any_hit  = ovf_sel || mat_sel;
    // two coincident selected events invert twice
    odd_hits = ovf_sel ^ mat_sel;
  end
endmodule

// File: rtl/tgo_level_reg.sv
module tgo_level_reg #(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic force_idle,
  input  logic idle_level,
  input  logic toggle_mode,
  input  logic any_hit,
  input  logic odd_hits,
  output logic level
);
  logic level_q;
  logic level_d;

  always_comb begin
    level_d = level_q;
    if (freeze) begin
      level_d = level_q;
    end else if (force_idle) begin
      level_d = idle_level;
    end else if (toggle_mode) begin
      if (odd_hits) level_d = ~level_q;
    end else begin
      level_d = any_hit ? ~idle_level : idle_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= RESET_LEVEL;
    else     level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/tmr_evt_out.sv
module tmr_evt_out
  import tgo_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovf_evt,
  input  logic              mat_evt,
  input  logic              running,
  input  logic              pin_is_input,
  input  logic [TRIG_W-1:0] trig_sel,
  input  logic              toggle_mode,
  input  logic              idle_level,
  output logic              pin_level
);
  logic any_hit;
  logic odd_hits;
  logic force_idle;

  assign force_idle = !running || !trig_active(trig_sel);

  tgo_event_sel u_sel (
    .ovf_evt  (ovf_evt),
    .mat_evt  (mat_evt),
    .trig_sel (trig_sel),
    .any_hit  (any_hit),
    .odd_hits (odd_hits)
  );

  tgo_level_reg #(.RESET_LEVEL(RESET_LEVEL)) u_lvl (
    .clk         (clk),
    .rst         (rst),
    .freeze      (pin_is_input),
    .force_idle  (force_idle),
    .idle_level  (idle_level),
    .toggle_mode (toggle_mode),
    .any_hit     (any_hit),
    .odd_hits    (odd_hits),
    .level       (pin_level)
  );
endmodule

// File: rtl/tmr_evt_out_chk.sv
module tmr_evt_out_chk (
  input logic       clk,
  input logic       rst,
  input logic       ovf_evt,
  input logic       mat_evt,
  input logic       running,
  input logic       pin_is_input,
  input logic [1:0] trig_sel,
  input logic       toggle_mode,
  input logic       idle_level,
  input logic       pin_level
);
  logic act;
  assign act = running && (trig_sel == 2'd1 || trig_sel == 2'd2);

  // R1
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !pin_level);

  // R3, R2 (reserved code idles)
  assert_idle_forced_R3: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && !act) |=> pin_level == $past(idle_level));

  // R4
  assert_input_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    pin_is_input |=> $stable(pin_level));

  // R5
  assert_toggle_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && act && toggle_mode && trig_sel == 2'd1 && ovf_evt)
      |=> pin_level != $past(pin_level));

  // R6
  assert_pulse_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && act && !toggle_mode && !ovf_evt && !mat_evt)
      |=> pin_level == $past(idle_level));

  // R7
  assert_match_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && running && trig_sel == 2'd1 && toggle_mode && !ovf_evt)
      |=> $stable(pin_level));

  // R8
  assert_coincident_cancel_R8: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && act && toggle_mode && trig_sel == 2'd2 && ovf_evt && mat_evt)
      |=> $stable(pin_level));
endmodule

bind tmr_evt_out tmr_evt_out_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ovf_evt      (ovf_evt),
  .mat_evt      (mat_evt),
  .running      (running),
  .pin_is_input (pin_is_input),
  .trig_sel     (trig_sel),
  .toggle_mode  (toggle_mode),
  .idle_level   (idle_level),
  .pin_level    (pin_level)
);

// File: tb/tmr_evt_out_bench.sv
`timescale 1ns/1ps
module tmr_evt_out_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ovf_evt = 1'b0;
  logic       mat_evt = 1'b0;
  logic       running = 1'b0;
  logic       pin_is_input = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic       toggle_mode = 1'b0;
  logic       idle_level = 1'b0;
  logic       pin_level;

  int    total = 0;
  int    bad = 0;
  int    exp_level = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  tmr_evt_out u_tmr_evt_out (
    .clk          (clk),
    .rst          (rst),
    .ovf_evt      (ovf_evt),
    .mat_evt      (mat_evt),
    .running      (running),
    .pin_is_input (pin_is_input),
    .trig_sel     (trig_sel),
    .toggle_mode  (toggle_mode),
    .idle_level   (idle_level),
    .pin_level    (pin_level)
  );

  // Behavioural reference: counts selected events and reacts to their number.
  function automatic int model_next(int cur, bit r, bit o, bit m, bit run,
                                    bit din, int t, bit tg, bit il);
    int n;
    if (r) return 0;
    if (din) return cur;
    if (!run || !(t == 1 || t == 2)) return il;
    n = 0;
    if (o) n++;
    if (m && t == 2) n++;
    if (tg) return (n % 2 == 1) ? 1 - cur : cur;
    return (n > 0) ? 1 - il : il;
  endfunction

  task automatic cyc(bit r, bit o, bit m, bit run, bit din, int t,
                     bit tg, bit il, string tag);
    @(negedge clk);
    total++;
    if (pin_level !== exp_level[0]) begin
      bad++;
      $display("FAIL %s: pin_level actual=%0b expected=%0d at %0t",
               cur_tag, pin_level, exp_level, $time);
    end
    rst = r; ovf_evt = o; mat_evt = m; running = run; pin_is_input = din;
    trig_sel = 2'(t); toggle_mode = tg; idle_level = il;
    exp_level = model_next(exp_level, r, o, m, run, din, t, tg, il);
    cur_tag = tag;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL R9: watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset
    cyc(1,0,0,0,0,0,0,0,"R1");
    cyc(0,0,0,0,0,0,0,0,"R1");
    // idle forced: stopped, none, reserved
    cyc(0,0,0,0,0,1,1,1,"R3");
    cyc(0,1,1,0,0,2,1,0,"R3");
    cyc(0,1,0,1,0,0,0,1,"R2");
    cyc(0,1,1,1,0,3,0,1,"R2");
    cyc(0,1,1,1,0,3,1,0,"R2");
    // toggle, overflow only
    cyc(0,0,0,1,0,1,1,0,"R5");
    cyc(0,1,0,1,0,1,1,0,"R5");
    cyc(0,0,0,1,0,1,1,0,"R5");
    cyc(0,1,0,1,0,1,1,0,"R5");
    cyc(0,0,1,1,0,1,1,0,"R7");
    cyc(0,0,1,1,0,1,1,0,"R7");
    cyc(0,1,0,1,0,1,1,0,"R5");
    // toggle with match enabled
    cyc(0,0,1,1,0,2,1,0,"R7");
    cyc(0,0,0,1,0,2,1,0,"R5");
    cyc(0,1,1,1,0,2,1,0,"R8");
    cyc(0,0,0,1,0,2,1,0,"R8");
    // direction freeze
    cyc(0,1,0,1,1,1,1,0,"R4");
    cyc(0,0,0,0,1,0,0,1,"R4");
    cyc(0,1,1,1,1,2,0,1,"R4");
    cyc(0,0,0,1,0,2,1,1,"R4");
    // pulse style, both idle polarities
    cyc(0,0,0,1,0,1,0,0,"R6");
    cyc(0,1,0,1,0,1,0,0,"R6");
    cyc(0,0,0,1,0,1,0,0,"R6");
    cyc(0,0,1,1,0,1,0,0,"R7");
    cyc(0,0,0,1,0,2,0,1,"R6");
    cyc(0,0,1,1,0,2,0,1,"R6");
    cyc(0,1,1,1,0,2,0,1,"R8");
    cyc(0,1,1,1,0,2,0,1,"R8");
    cyc(0,0,0,1,0,2,0,1,"R8");
    // reset mid-run
    cyc(1,1,0,1,0,1,1,1,"R1");
    cyc(0,0,0,1,0,1,1,1,"R1");
    // randomized mix
    for (int i = 0; i < 3000; i++) begin
      cyc((($urandom % 97) == 0), $urandom % 2, $urandom % 2,
          ($urandom % 8) != 0, ($urandom % 10) == 0, $urandom % 4,
          $urandom % 2, ($urandom % 16) == 0 ? ~idle_level : idle_level, "R9");
    end
    cyc(0,0,0,0,0,0,0,0,"R9");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule